// File: doc/BRIEF.md
# Lazy Recovery Tree Node Checker

After a crash, the integrity tree over the volatile part of memory is rebuilt only from its lowest interior level. Every node on that level is written as all zeros, and the levels above are hashed from those zero nodes. This block then fixes up each counter block lazily, on its first update after recovery. It is given a counter block, its 64-byte parent node, the 3-bit position of the block's 8-byte MAC slot inside the parent, and the line that is being written. It reads that slot. A zero slot does not mean tampering. It marks a block that has not been touched since recovery, so the counter block starts again from zero before the update is applied. A non-zero slot takes the normal path: the stored block is verified against the slot, and then the update is applied.

The block never leaves a MAC of zero in a parent slot, because zero is reserved as the untouched marker. When a freshly computed MAC is zero, the block increments the written line's minor counter again and rehashes. The number of such retries is limited by a parameter. The MAC is a keyed 64-bit mixing function that stands in for a real one. It takes one 64-bit word per cycle, and a start/done handshake wraps it.

Top module: `lazyTreeNodeChecker`

## Requirements
- R1: After reset, `busy`, `done`, `firstWrite` and `integrityErr` are all low.
- R2: `start` is accepted only while `busy` is low. `done` is a pulse one cycle wide. A `start` raised while busy has no effect on the result or on its timing. All outputs hold their values until the next accepted `start`.
- R3: The MAC begins with the accumulator equal to the `MAC_KEY` parameter. It takes the eight 64-bit words of the counter block from least significant to most significant. For each word w, acc = rotl17(acc ^ w) * 64'h9E3779B97F4A7C15, kept to 64 bits. Slot k of a parent node is bits [64k+63:64k].
- R4: In a counter block, bits [63:0] hold the major counter and bits [64+7L+6:64+7L] hold the minor counter of line L. An update increments the minor counter of `lineIdx`.
- R5: When the minor counter being incremented is 127, the update adds one to the major counter and clears all 64 minor counters.
- R6: A zero slot gives `firstWrite`=1 and `integrityErr`=0. The output counter block is the all-zero block with the update applied, whatever `ctrIn` holds. The slot receives the new MAC.
- R7: A non-zero slot that matches the MAC of `ctrIn` gives `firstWrite`=0 and `integrityErr`=0. The output counter block is the updated block, the slot holds that block's MAC, and the other seven slots are unchanged.
- R8: A non-zero slot that differs from the MAC of `ctrIn` raises `integrityErr`. `ctrOut` and `parentOut` then equal `ctrIn` and `parentIn`.
- R9: A new MAC equal to zero triggers another increment of the same line's minor counter (R4/R5) and a rehash. A completed result never leaves a zero slot.
- R10: If the MAC is still zero after `MAX_RETRY` extra increments, `integrityErr` is raised and the outputs equal the inputs, as in R8.
- R11: Counted in rising edges after the edge that accepts `start`, `done` is high after 11 edges on the first-write path, 20 on the verify path and 10 on a mismatch. Each zero-MAC retry adds 10 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| ctrIn | input | 512 | Counter block as stored |
| parentIn | input | 512 | Parent node holding eight MAC slots |
| childIdx | input | 3 | Slot of this block within the parent |
| lineIdx | input | 6 | Line whose minor counter is written |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrOut | output | 512 | Resulting counter block |
| parentOut | output | 512 | Resulting parent node |
| firstWrite | output | 1 | Request took the untouched-since-recovery path |
| integrityErr | output | 1 | Verification failed or retry bound was exceeded |

## Verification
The first-write path completes 11 edges after acceptance, the verify path 20 and the mismatch path 10. Each zero-MAC retry adds 10 edges, so one retry on the verify path finishes at 30 edges. The bench counts rising edges from the accepting edge and samples on the falling edge that follows each one. Each check compares the edge count at which `done` is first seen against the count expected for that path. Results are read in that same half cycle and read again later, to confirm that they are held. To reach the retry and bound cases on purpose, a counter block is built so that its updated image hashes to exactly zero.

// File: rtl/lazyTreePkg.sv
package lazyTreePkg;
  localparam int NODE_BITS  = 512;
  localparam int SLOT_BITS  = 64;
  localparam int FANOUT     = NODE_BITS / SLOT_BITS;
  localparam int IDX_BITS   = $clog2(FANOUT);
  localparam int MAJOR_BITS = 64;
  localparam int MINOR_BITS = 7;
  localparam int LINES      = (NODE_BITS - MAJOR_BITS) / MINOR_BITS;
  localparam int LINE_BITS  = $clog2(LINES);
  localparam int MIX_ROT    = 17;
  localparam logic [SLOT_BITS-1:0] MIX_MULT = 64'h9E37_79B9_7F4A_7C15;

  typedef struct packed {
    logic load;
    logic clearCtr;
    logic macStart;
    logic macStep;
    logic bump;
    logic setErr;
  } dpCtl_t;

  function automatic logic [SLOT_BITS-1:0] macMix(input logic [SLOT_BITS-1:0] acc,
                                                   input logic [SLOT_BITS-1:0] word);
    logic [SLOT_BITS-1:0] t;
    t = acc ^ word;
    return ((t << MIX_ROT) | (t >> (SLOT_BITS - MIX_ROT))) * MIX_MULT;
  endfunction
endpackage

// File: rtl/lazyTreeDatapath.sv
module lazyTreeDatapath import lazyTreePkg::*; #(
  parameter logic [SLOT_BITS-1:0] MAC_KEY = 64'h0123_4567_89AB_CDEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpCtl_t               ctl,
  input  logic [NODE_BITS-1:0] ctrIn,
  input  logic [NODE_BITS-1:0] parentIn,
  input  logic [IDX_BITS-1:0]  childIdxIn,
  input  logic [LINE_BITS-1:0] lineIdxIn,
  output logic                 slotZero,
  output logic                 macLast,
  output logic                 macMatch,
  output logic                 macZero,
  output logic [NODE_BITS-1:0] ctrOut,
  output logic [NODE_BITS-1:0] parentOut,
  output logic                 errFlag,
  output logic                 firstFlag
);
  logic [NODE_BITS-1:0] origCtr, origParent, workCtr, bumped;
  logic [IDX_BITS-1:0]  childIdx, wordCnt;
  logic [LINE_BITS-1:0] lineIdx;
  logic [SLOT_BITS-1:0] macAcc, slotVal, curWord;
  logic [MINOR_BITS-1:0] curMinor;

  always_comb begin
    slotVal  = origParent[int'(childIdx)*SLOT_BITS +: SLOT_BITS];
    curWord  = workCtr[int'(wordCnt)*SLOT_BITS +: SLOT_BITS];
    curMinor = workCtr[MAJOR_BITS + int'(lineIdx)*MINOR_BITS +: MINOR_BITS];
    slotZero = (slotVal == '0);
    macMatch = (macAcc == slotVal);
    macZero  = (macAcc == '0);
    macLast  = (wordCnt == IDX_BITS'(FANOUT - 1));
  end

  // Minor counter increment; a saturated minor rolls into the major counter.
  always_comb begin
    bumped = workCtr;
    if (curMinor == '1) begin
      bumped[MAJOR_BITS-1:0]         = workCtr[MAJOR_BITS-1:0] + 1'b1;
      bumped[NODE_BITS-1:MAJOR_BITS] = '0;
    end else begin
      bumped[MAJOR_BITS + int'(lineIdx)*MINOR_BITS +: MINOR_BITS] = curMinor + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origCtr    <= '0;
      origParent <= '0;
      workCtr    <= '0;
      childIdx   <= '0;
      lineIdx    <= '0;
      macAcc     <= '0;
      wordCnt    <= '0;
      errFlag    <= 1'b0;
      firstFlag  <= 1'b0;
    end else begin
      if (ctl.load) begin
        origCtr    <= ctrIn;
        origParent <= parentIn;
        workCtr    <= ctrIn;
        childIdx   <= childIdxIn;
        lineIdx    <= lineIdxIn;
        errFlag    <= 1'b0;
        firstFlag  <= 1'b0;
      end
      if (ctl.clearCtr) begin
        workCtr   <= '0;
        firstFlag <= 1'b1;
      end
      if (ctl.bump) workCtr <= bumped;
      if (ctl.macStart) begin
        macAcc  <= MAC_KEY;
        wordCnt <= '0;
      end
      if (ctl.macStep) begin
        macAcc  <= macMix(macAcc, curWord);
        wordCnt <= wordCnt + 1'b1;
      end
      if (ctl.setErr) begin
        errFlag   <= 1'b1;
        firstFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrOut    = errFlag ? origCtr : workCtr;
    parentOut = origParent;
    if (!errFlag) parentOut[int'(childIdx)*SLOT_BITS +: SLOT_BITS] = macAcc;
  end
endmodule

// File: rtl/lazyTreeControl.sv
module lazyTreeControl import lazyTreePkg::*; #(
  parameter int MAX_RETRY = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   slotZero,
  input  logic   macLast,
  input  logic   macMatch,
  input  logic   macZero,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int RETRY_BITS = $clog2(MAX_RETRY + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_CLASSIFY, S_VERIFY, S_COMPARE, S_BUMP, S_HASH, S_CHECKZ, S_DONE
  } state_t;

  state_t state, nextState;
  logic [RETRY_BITS-1:0] retryCnt;
  logic retryLeft;

  assign retryLeft = int'(retryCnt) < MAX_RETRY;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load  = 1'b1;
        nextState = S_CLASSIFY;
      end
      S_CLASSIFY: begin
        if (slotZero) begin
          ctl.clearCtr = 1'b1;
          nextState    = S_BUMP;
        end else begin
          ctl.macStart = 1'b1;
          nextState    = S_VERIFY;
        end
      end
      S_VERIFY: begin
        ctl.macStep = 1'b1;
        if (macLast) nextState = S_COMPARE;
      end
      S_COMPARE: begin
        if (macMatch) nextState = S_BUMP;
        else begin
          ctl.setErr = 1'b1;
          nextState  = S_DONE;
        end
      end
      S_BUMP: begin
        ctl.bump     = 1'b1;
        ctl.macStart = 1'b1;
        nextState    = S_HASH;
      end
      S_HASH: begin
        ctl.macStep = 1'b1;
        if (macLast) nextState = S_CHECKZ;
      end
      S_CHECKZ: begin
        if (!macZero) nextState = S_DONE;
        else if (retryLeft) nextState = S_BUMP;
        else begin
          ctl.setErr = 1'b1;
          nextState  = S_DONE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      retryCnt <= '0;
    end else begin
      state <= nextState;
      if (ctl.load) retryCnt <= '0;
      else if (state == S_CHECKZ && macZero && retryLeft) retryCnt <= retryCnt + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/lazyTreeNodeChecker.sv
module lazyTreeNodeChecker import lazyTreePkg::*; #(
  parameter logic [SLOT_BITS-1:0] MAC_KEY = 64'h0123_4567_89AB_CDEF,
  parameter int MAX_RETRY = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NODE_BITS-1:0] ctrIn,
  input  logic [NODE_BITS-1:0] parentIn,
  input  logic [IDX_BITS-1:0]  childIdx,
  input  logic [LINE_BITS-1:0] lineIdx,
  output logic                 busy,
  output logic                 done,
  output logic [NODE_BITS-1:0] ctrOut,
  output logic [NODE_BITS-1:0] parentOut,
  output logic                 firstWrite,
  output logic                 integrityErr
);
  dpCtl_t ctl;
  logic slotZero, macLast, macMatch, macZero;

  lazyTreeControl #(.MAX_RETRY(MAX_RETRY)) u_control (
    .clk(clk), .rst_n(rst_n), .start(start),
    .slotZero(slotZero), .macLast(macLast), .macMatch(macMatch), .macZero(macZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  lazyTreeDatapath #(.MAC_KEY(MAC_KEY)) u_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .ctrIn(ctrIn), .parentIn(parentIn), .childIdxIn(childIdx), .lineIdxIn(lineIdx),
    .slotZero(slotZero), .macLast(macLast), .macMatch(macMatch), .macZero(macZero),
    .ctrOut(ctrOut), .parentOut(parentOut), .errFlag(integrityErr), .firstFlag(firstWrite)
  );
endmodule

// File: rtl/lazyTreeNodeCheckerSva.sv
module lazyTreeNodeCheckerSva import lazyTreePkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [NODE_BITS-1:0] ctrIn,
  input logic [NODE_BITS-1:0] parentIn,
  input logic [IDX_BITS-1:0]  childIdx,
  input logic [LINE_BITS-1:0] lineIdx,
  input logic                 busy,
  input logic                 done,
  input logic [NODE_BITS-1:0] ctrOut,
  input logic [NODE_BITS-1:0] parentOut,
  input logic                 firstWrite,
  input logic                 integrityErr
);
  logic [NODE_BITS-1:0] capCtr, capParent, slotMask, lineMask;
  logic [IDX_BITS-1:0]  capIdx;
  logic [LINE_BITS-1:0] capLine;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capCtr <= '0; capParent <= '0; capIdx <= '0; capLine <= '0;
    end else if (start && !busy) begin
      capCtr <= ctrIn; capParent <= parentIn; capIdx <= childIdx; capLine <= lineIdx;
    end
  end

  always_comb begin
    slotMask = '0;
    slotMask[int'(capIdx)*SLOT_BITS +: SLOT_BITS] = '1;
    lineMask = '0;
    lineMask[MAJOR_BITS + int'(capLine)*MINOR_BITS +: MINOR_BITS] = '1;
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  p_first_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && firstWrite) |-> (!integrityErr && ((ctrOut & ~lineMask) == '0)));
  p_other_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((parentOut & ~slotMask) == (capParent & ~slotMask)));
  p_err_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && integrityErr) |-> (ctrOut == capCtr && parentOut == capParent));
  p_slot_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !integrityErr) |-> ((parentOut & slotMask) != '0));
endmodule

bind lazyTreeNodeChecker lazyTreeNodeCheckerSva u_sva (.*);

// File: tb/lazyTreeNodeChecker_bench.sv
module lazyTreeNodeChecker_bench;
  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] MULT = 64'h9E37_79B9_7F4A_7C15;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [511:0] ctrIn = '0, parentIn = '0;
  logic [2:0] childIdx = '0;
  logic [5:0] lineIdx = '0;
  logic busy, done, firstWrite, integrityErr;
  logic [511:0] ctrOut, parentOut;
  logic sBusy, sDone, sFirst, sErr;
  logic [511:0] sCtr, sParent;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  lazyTreeNodeChecker #(.MAC_KEY(KEY), .MAX_RETRY(3)) u_lazyTreeNodeChecker (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrIn(ctrIn), .parentIn(parentIn),
    .childIdx(childIdx), .lineIdx(lineIdx), .busy(busy), .done(done), .ctrOut(ctrOut),
    .parentOut(parentOut), .firstWrite(firstWrite), .integrityErr(integrityErr));

  lazyTreeNodeChecker #(.MAC_KEY(KEY), .MAX_RETRY(0)) u_lazyTreeNodeChecker_strict (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrIn(ctrIn), .parentIn(parentIn),
    .childIdx(childIdx), .lineIdx(lineIdx), .busy(sBusy), .done(sDone), .ctrOut(sCtr),
    .parentOut(sParent), .firstWrite(sFirst), .integrityErr(sErr));

  function automatic logic [63:0] mixStep(logic [63:0] acc, logic [63:0] w);
    logic [63:0] t = acc ^ w;
    return {t[46:0], t[63:47]} * MULT;
  endfunction

  function automatic logic [63:0] macOf(logic [511:0] b);
    logic [63:0] acc = KEY;
    for (int i = 0; i < 8; i++) acc = mixStep(acc, b[i*64 +: 64]);
    return acc;
  endfunction

  function automatic logic [511:0] bumpLine(logic [511:0] b, int line);
    logic [511:0] r = b;
    if (b[64 + line*7 +: 7] == 7'd127) begin
      r[63:0] = b[63:0] + 64'd1;
      r[511:64] = '0;
    end else r[64 + line*7 +: 7] = b[64 + line*7 +: 7] + 7'd1;
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one request; return edges from the accepting edge until done is seen.
  task automatic runOp(logic [511:0] c, logic [511:0] p, int idx, int line, output int lat);
    @(negedge clk);
    ctrIn = c; parentIn = p; childIdx = 3'(idx); lineIdx = 6'(line); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!done && lat < 200);
  endtask

  task automatic testReset();
    check(!busy && !done && !firstWrite && !integrityErr, "R1", "idle outputs after reset",
          {busy, done, firstWrite, integrityErr}, '0);
  endtask

  task automatic testFirstWrite();
    logic [511:0] p = rnd512(), expC, expP;
    int lat, tries = 0;
    p[3*64 +: 64] = '0;
    expC = bumpLine('0, 10);
    while (macOf(expC) == '0 && tries < 3) begin expC = bumpLine(expC, 10); tries++; end
    expP = p; expP[3*64 +: 64] = macOf(expC);
    runOp(rnd512(), p, 3, 10, lat);
    check(lat == 11 + 10*tries, "R11", "first-write latency", lat, 11 + 10*tries);
    check(firstWrite && !integrityErr, "R6", "first-write flags", {firstWrite, integrityErr}, 2'b10);
    check(ctrOut == expC, "R6", "counter reset then updated", ctrOut, expC);
    check(parentOut == expP, "R6", "slot filled with new MAC", parentOut, expP);
  endtask

  task automatic testVerify();
    logic [511:0] c = rnd512(), p = rnd512(), expC, expP;
    int lat;
    c[64 + 5*7 +: 7] = 7'd20;
    p[6*64 +: 64] = macOf(c);
    expC = bumpLine(c, 5);
    expP = p; expP[6*64 +: 64] = macOf(expC);
    runOp(c, p, 6, 5, lat);
    check(lat == 20, "R11", "verify-path latency", lat, 20);
    check(!firstWrite && !integrityErr, "R7", "verify flags", {firstWrite, integrityErr}, '0);
    check(ctrOut[64 + 5*7 +: 7] == 7'd21, "R4", "minor incremented", ctrOut[64 + 5*7 +: 7], 21);
    check(ctrOut == expC, "R7", "updated block", ctrOut, expC);
    check(parentOut == expP, "R3", "new MAC in slot, others kept", parentOut, expP);
    repeat (3) @(negedge clk);
    check(!done && ctrOut == expC, "R2", "done one cycle, outputs held", ctrOut, expC);
  endtask

  task automatic testMismatch();
    logic [511:0] c = rnd512(), p = rnd512();
    int lat;
    p[1*64 +: 64] = macOf(c) ^ 64'h1;
    runOp(c, p, 1, 2, lat);
    check(lat == 10, "R11", "mismatch latency", lat, 10);
    check(integrityErr && !firstWrite, "R8", "tamper flags", {firstWrite, integrityErr}, 2'b01);
    check(ctrOut == c && parentOut == p, "R8", "outputs equal inputs", parentOut, p);
  endtask

  task automatic testOverflow();
    logic [511:0] c = rnd512(), p = rnd512(), expC, expP;
    int lat;
    c[64 + 9*7 +: 7] = 7'd127;
    p[0 +: 64] = macOf(c);
    expC = '0; expC[63:0] = c[63:0] + 64'd1;
    expP = p; expP[0 +: 64] = macOf(expC);
    runOp(c, p, 0, 9, lat);
    check(ctrOut == expC, "R5", "major bumped, minors cleared", ctrOut, expC);
    check(parentOut == expP && !integrityErr, "R5", "slot after rollover", parentOut, expP);
  endtask

  task automatic testZeroMac();
    logic [511:0] s = rnd512(), u, expC, p = rnd512(), expP;
    logic [63:0] acc = KEY;
    int lat;
    s[64 +: 7] = 7'd5;
    u = s; u[64 +: 7] = 7'd6;
    for (int i = 0; i < 7; i++) acc = mixStep(acc, u[i*64 +: 64]);
    u[7*64 +: 64] = acc; s[7*64 +: 64] = acc;
    check(macOf(u) == '0, "R9", "crafted image hashes to zero", macOf(u), '0);
    p[2*64 +: 64] = macOf(s);
    expC = bumpLine(u, 0);
    expP = p; expP[2*64 +: 64] = macOf(expC);
    runOp(s, p, 2, 0, lat);
    check(lat == 30, "R11", "one retry adds ten edges", lat, 30);
    check(ctrOut == expC && !integrityErr, "R9", "line bumped again", ctrOut, expC);
    check(parentOut == expP && parentOut[2*64 +: 64] != '0, "R9", "nonzero slot", parentOut, expP);
    check(sErr && !sFirst, "R10", "bound zero raises error", {sFirst, sErr}, 2'b01);
    check(sCtr == s && sParent == p, "R10", "outputs equal inputs", sCtr, s);
  endtask

  task automatic testBusyStart();
    logic [511:0] c = rnd512(), p = rnd512(), expC, expP;
    int lat;
    c[64 + 30*7 +: 7] = 7'd3;
    p[4*64 +: 64] = macOf(c);
    expC = bumpLine(c, 30);
    expP = p; expP[4*64 +: 64] = macOf(expC);
    @(negedge clk);
    ctrIn = c; parentIn = p; childIdx = 3'd4; lineIdx = 6'd30; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; lat = 0;
    repeat (3) begin @(posedge clk); lat++; @(negedge clk); end
    ctrIn = rnd512(); parentIn = '0; childIdx = 3'd1; lineIdx = 6'd7; start = 1'b1;
    @(posedge clk); lat++;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
    check(lat == 20, "R2", "start while busy keeps timing", lat, 20);
    check(ctrOut == expC && parentOut == expP, "R2", "start while busy ignored", parentOut, expP);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFirstWrite();
    testVerify();
    testMismatch();
    testOverflow();
    testZeroMac();
    testBusyStart();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule